// File: doc/BRIEF.md
# Region Protection Address Translator

This block maps virtual addresses to physical addresses and checks access rights on a processor that has no paged memory management. The 32-bit space is divided into eight equal regions of 512 MB. The top three bits of the virtual address select the region. Each region has an entry with a physical region base and a 4-bit attribute code. The attribute code decides whether reads, writes and instruction fetches may proceed.

Two independent tables are built. One serves instruction fetches and the other serves loads and stores. Software reprograms any entry of either table through a single write port. Each request returns the physical address, a grant flag, a fault cause and the fixed region size, one cycle after it is presented.

A parameter can remove protection entirely. The address then passes through unchanged and every access is granted.

Top module: `rgn_xlat`

## Requirements
- R1: After reset, entry i of both tables maps region i to physical region i with attribute 2, so every access to any region is granted with an unchanged address.
- R2: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high, and low after a cycle without a request.
- R3: The region index is `reqAddr[31:29]`. `rspPaddr` is the selected entry's base in bits [31:29], ORed with `reqAddr[28:0]`.
- R4: Loads and stores are granted when the attribute is below 6 and not 3, or when it equals 14.
- R5: Fetches are granted when the attribute lies between 1 and 5 inclusive.
- R6: `reqKind` encodes 0 = fetch, 1 = load, 2 = store and 3 = load. `rspCause` is 0 when the access is granted. A denied fetch gives 20, a denied load gives 28 and a denied store gives 29.
- R7: An entry write presented in a cycle takes effect for lookups presented in later cycles. A lookup presented in the same cycle still sees the old entry.
- R8: `wrTable` = 0 writes the instruction table, which fetches use. `wrTable` = 1 writes the data table, which loads and stores use. A write to one table leaves the other unchanged.
- R9: `rspPageSize` reports the region size, 0x2000_0000.
- R10: With `PROTECT_EN` = 0, `rspPaddr` equals the virtual address, every access is granted and `rspCause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request this cycle |
| reqKind | input | 2 | Access type: 0 fetch, 1 load, 2 store, 3 load |
| reqAddr | input | 32 | Virtual address |
| wrEn | input | 1 | Entry write strobe |
| wrTable | input | 1 | 0 instruction table, 1 data table |
| wrIdx | input | 3 | Entry to write |
| wrBase | input | 3 | New physical region base |
| wrAttr | input | 4 | New attribute code |
| rspValid | output | 1 | Response valid |
| rspPaddr | output | 32 | Physical address |
| rspGranted | output | 1 | Access permitted |
| rspCause | output | 6 | Fault cause, 0 when granted |
| rspPageSize | output | 32 | Region size in bytes |

## Verification
The assertions check on every cycle:
- the one-cycle response timing;
- that the low 29 address bits are kept;
- that a granted access carries cause 0;
- that each denied access type carries its own cause code.

Only the bench scenarios can show the attribute decoding rules, the routing of accesses to the two separate tables, the write-versus-lookup ordering, the reset mapping and the pass-through variant. The bench shows these by sweeping every attribute over every entry of both tables, for all access types.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  localparam int CAUSE_W = 6;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } accKind_t;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE       = 6'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_DENY = 6'd20;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_DENY  = 6'd28;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29;

  // strobes from control to datapath
  typedef struct packed {
    logic       lookup;
    logic       useData;
    logic       needExec;
    logic       isStore;
    logic [1:0] wrSel;    // one-hot: [0] instruction table, [1] data table
  } ctrlStrobe_t;
endpackage

// File: rtl/rgn_table.sv
module rgn_table #(
  parameter int IDX_W  = 3,
  parameter int ATTR_W = 4,
  parameter int RESET_ATTR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  wrBase,
  input  logic [ATTR_W-1:0] wrAttr,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  rdBase,
  output logic [ATTR_W-1:0] rdAttr
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]  baseMem [ENTRIES];
  logic [ATTR_W-1:0] attrMem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseMem[e] <= IDX_W'(e);
        attrMem[e] <= ATTR_W'(RESET_ATTR);
      end else if (wrEn && wrIdx == IDX_W'(e)) begin
        baseMem[e] <= wrBase;
        attrMem[e] <= wrAttr;
      end
    end
  end

  assign rdBase = baseMem[rdIdx];
  assign rdAttr = attrMem[rdIdx];
endmodule

// File: rtl/rgn_ctrl.sv
module rgn_ctrl import rgn_pkg::*; (
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic        wrEn,
  input  logic        wrTable,
  output ctrlStrobe_t strb
);
  accKind_t kind;

  always_comb begin
    kind          = accKind_t'(reqKind);
    strb.lookup   = reqValid;
    strb.needExec = (kind == ACC_FETCH);
    strb.useData  = (kind != ACC_FETCH);
    strb.isStore  = (kind == ACC_STORE);
    strb.wrSel    = 2'b00;
    if (wrEn) strb.wrSel = wrTable ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/rgn_datapath.sv
module rgn_datapath import rgn_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 3,
  parameter int ATTR_W     = 4,
  parameter int PROTECT_EN = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   wrBase,
  input  logic [ATTR_W-1:0]  wrAttr,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspPaddr,
  output logic               rspGranted,
  output logic [CAUSE_W-1:0] rspCause
);
  localparam int OFS_W   = ADDR_W - IDX_W;
  localparam int NUM_TBL = 2;

  logic [IDX_W-1:0]   lkIdx;
  logic [ADDR_W-1:0]  nxtPaddr;
  logic               nxtGranted;
  logic [CAUSE_W-1:0] nxtCause;

  assign lkIdx = reqAddr[ADDR_W-1 -: IDX_W];

  if (PROTECT_EN != 0) begin : gProt
    logic [IDX_W-1:0]  tblBase [NUM_TBL];
    logic [ATTR_W-1:0] tblAttr [NUM_TBL];
    logic [IDX_W-1:0]  selBase;
    logic [ATTR_W-1:0] selAttr;
    logic              canRw;
    logic              canExec;

    for (genvar t = 0; t < NUM_TBL; t++) begin : gTbl
      rgn_table #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .RESET_ATTR(2)) u_tbl (
        .clk    (clk),
        .rstN   (rstN),
        .wrEn   (strb.wrSel[t]),
        .wrIdx  (wrIdx),
        .wrBase (wrBase),
        .wrAttr (wrAttr),
        .rdIdx  (lkIdx),
        .rdBase (tblBase[t]),
        .rdAttr (tblAttr[t])
      );
    end

    always_comb begin
      selBase    = strb.useData ? tblBase[1] : tblBase[0];
      selAttr    = strb.useData ? tblAttr[1] : tblAttr[0];
      canRw      = ((selAttr < ATTR_W'(6)) && (selAttr != ATTR_W'(3)))
                   || (selAttr == ATTR_W'(14));
      canExec    = (selAttr >= ATTR_W'(1)) && (selAttr <= ATTR_W'(5));
      nxtGranted = strb.needExec ? canExec : canRw;
      nxtPaddr   = {selBase, reqAddr[OFS_W-1:0]};
    end
  end else begin : gPass
    assign nxtPaddr   = reqAddr;
    assign nxtGranted = 1'b1;
  end

  always_comb begin
    if (nxtGranted)         nxtCause = CAUSE_NONE;
    else if (strb.needExec) nxtCause = CAUSE_FETCH_DENY;
    else if (strb.isStore)  nxtCause = CAUSE_STORE_DENY;
    else                    nxtCause = CAUSE_LOAD_DENY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspPaddr   <= '0;
      rspGranted <= 1'b0;
      rspCause   <= CAUSE_NONE;
    end else begin
      rspValid <= strb.lookup;
      if (strb.lookup) begin
        rspPaddr   <= nxtPaddr;
        rspGranted <= nxtGranted;
        rspCause   <= nxtCause;
      end
    end
  end
endmodule

// File: rtl/rgn_xlat.sv
module rgn_xlat import rgn_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 3,
  parameter int ATTR_W     = 4,
  parameter int PROTECT_EN = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               wrEn,
  input  logic               wrTable,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   wrBase,
  input  logic [ATTR_W-1:0]  wrAttr,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspPaddr,
  output logic               rspGranted,
  output logic [CAUSE_W-1:0] rspCause,
  output logic [ADDR_W-1:0]  rspPageSize
);
  localparam int OFS_W = ADDR_W - IDX_W;

  ctrlStrobe_t strb;

  rgn_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .wrEn     (wrEn),
    .wrTable  (wrTable),
    .strb     (strb)
  );

  rgn_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ATTR_W(ATTR_W), .PROTECT_EN(PROTECT_EN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .wrIdx      (wrIdx),
    .wrBase     (wrBase),
    .wrAttr     (wrAttr),
    .rspValid   (rspValid),
    .rspPaddr   (rspPaddr),
    .rspGranted (rspGranted),
    .rspCause   (rspCause)
  );

  assign rspPageSize = ADDR_W'(1) << OFS_W;
endmodule

// File: rtl/rgn_xlat_chk.sv
module rgn_xlat_chk import rgn_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [1:0]         reqKind,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               rspValid,
  input logic [ADDR_W-1:0]  rspPaddr,
  input logic               rspGranted,
  input logic [CAUSE_W-1:0] rspCause
);
  localparam int OFS_W = ADDR_W - IDX_W;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R2
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);  // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspPaddr[OFS_W-1:0] == $past(reqAddr[OFS_W-1:0])));  // R3
  AST_GRANT_NO_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspGranted) |-> (rspCause == CAUSE_NONE));  // R6
  AST_FETCH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0) |=> (rspGranted || rspCause == CAUSE_FETCH_DENY));  // R6
  AST_STORE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2) |=> (rspGranted || rspCause == CAUSE_STORE_DENY));  // R6
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind[0]) |=> (rspGranted || rspCause == CAUSE_LOAD_DENY));  // R6
endmodule

bind rgn_xlat rgn_xlat_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqKind    (reqKind),
  .reqAddr    (reqAddr),
  .rspValid   (rspValid),
  .rspPaddr   (rspPaddr),
  .rspGranted (rspGranted),
  .rspCause   (rspCause)
);

// File: tb/rgn_xlat_tb.sv
module rgn_xlat_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [31:0] reqAddr = '0;
  logic        wrEn = 1'b0;
  logic        wrTable = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [2:0]  wrBase = '0;
  logic [3:0]  wrAttr = '0;

  logic        rspValid, rspGranted, pValid, pGranted;
  logic [31:0] rspPaddr, rspPageSize, pPaddr, pPageSize;
  logic [5:0]  rspCause, pCause;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [2:0] shBase [2][8];
  logic [3:0] shAttr [2][8];

  always #5ns clk = ~clk;

  rgn_xlat u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .wrEn(wrEn), .wrTable(wrTable), .wrIdx(wrIdx), .wrBase(wrBase), .wrAttr(wrAttr),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspGranted(rspGranted),
    .rspCause(rspCause), .rspPageSize(rspPageSize)
  );

  rgn_xlat #(.PROTECT_EN(0)) u_dutPass (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .wrEn(wrEn), .wrTable(wrTable), .wrIdx(wrIdx), .wrBase(wrBase), .wrAttr(wrAttr),
    .rspValid(pValid), .rspPaddr(pPaddr), .rspGranted(pGranted),
    .rspCause(pCause), .rspPageSize(pPageSize)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expRw(input logic [3:0] a);
    return ((a < 4'd6) && (a != 4'd3)) || (a == 4'd14);
  endfunction

  function automatic bit expExec(input logic [3:0] a);
    return (a >= 4'd1) && (a <= 4'd5);
  endfunction

  task automatic checkRsp(input logic [31:0] addr, input logic [1:0] kind);
    int t;
    int i;
    bit g;
    logic [5:0] c;
    logic [31:0] pa;
    t  = (kind == 2'd0) ? 0 : 1;
    i  = int'(addr[31:29]);
    g  = (kind == 2'd0) ? expExec(shAttr[t][i]) : expRw(shAttr[t][i]);
    c  = g ? 6'd0 : (kind == 2'd0) ? 6'd20 : (kind == 2'd2) ? 6'd29 : 6'd28;
    pa = {shBase[t][i], addr[28:0]};
    chk(rspValid == 1'b1, "R2 rspValid", 64'(rspValid), 64'd1);
    chk(rspPaddr == pa, "R3 R8 rspPaddr", 64'(rspPaddr), 64'(pa));
    chk(rspGranted == g, (kind == 2'd0) ? "R5 R8 grant" : "R4 R8 grant", 64'(rspGranted), 64'(g));
    chk(rspCause == c, "R6 cause", 64'(rspCause), 64'(c));
    chk(rspPageSize == 32'h2000_0000, "R9 page size", 64'(rspPageSize), 64'h2000_0000);
    chk(pPaddr == addr && pGranted && pCause == 6'd0, "R10 pass-through",
        {pPaddr, 26'd0, pCause}, {addr, 26'd0, 6'd0});
  endtask

  task automatic doReq(input logic [31:0] addr, input logic [1:0] kind);
    reqValid = 1'b1; reqAddr = addr; reqKind = kind;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    checkRsp(addr, kind);
  endtask

  task automatic doWrite(input bit tbl, input int idx, input logic [2:0] base, input logic [3:0] attr);
    wrEn = 1'b1; wrTable = tbl; wrIdx = 3'(idx); wrBase = base; wrAttr = attr;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    shBase[tbl][idx] = base;
    shAttr[tbl][idx] = attr;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) begin
        shBase[t][i] = 3'(i);
        shAttr[t][i] = 4'd2;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 and R2: registered outputs are at their reset values
    chk(rspValid == 1'b0, "R1 R2 reset rspValid", 64'(rspValid), 64'd0);
    chk(rspGranted == 1'b0 && rspCause == 6'd0, "R1 reset grant/cause",
        64'({rspGranted, rspCause}), 64'd0);

    // R1: identity map with attribute 2, all kinds granted
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 4; k++) begin
        doReq({3'(i), 29'h0123_4567 + 29'(k * 13)}, 2'(k));
        chk(rspGranted && rspPaddr[31:29] == 3'(i), "R1 reset mapping",
            64'({rspGranted, rspPaddr}), 64'({1'b1, 3'(i), rspPaddr[28:0]}));
      end

    // R2: an idle cycle gives no response
    @(negedge clk);
    chk(rspValid == 1'b0, "R2 idle", 64'(rspValid), 64'd0);

    // R3 R4 R5 R6 R8: sweep every attribute over every entry of both tables
    for (int t = 0; t < 2; t++)
      for (int a = 0; a < 16; a++) begin
        for (int i = 0; i < 8; i++)
          doWrite(t[0], i, 3'(7 - i), 4'(a));
        for (int i = 0; i < 8; i++)
          for (int k = 0; k < 4; k++)
            doReq({3'(i), 29'h0ABC_123 + 29'(i * 32'h0111_1111) + 29'(k * 7 + a)}, 2'(k));
      end

    // R7: a write and a lookup in the same cycle; the lookup sees the old entry
    doWrite(1'b1, 5, 3'd2, 4'd4);
    wrEn = 1'b1; wrTable = 1'b1; wrIdx = 3'd5; wrBase = 3'd6; wrAttr = 4'd15;
    reqValid = 1'b1; reqAddr = {3'd5, 29'h1555_AAAA}; reqKind = 2'd1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    chk(rspGranted == 1'b1 && rspPaddr == {3'd2, 29'h1555_AAAA}, "R7 same-cycle old entry",
        64'({rspGranted, rspPaddr}), 64'({1'b1, 3'd2, 29'h1555_AAAA}));
    shBase[1][5] = 3'd6;
    shAttr[1][5] = 4'd15;
    doReq({3'd5, 29'h1555_AAAA}, 2'd1);
    chk(rspGranted == 1'b0 && rspCause == 6'd28, "R7 next-cycle new entry",
        64'({rspGranted, rspCause}), 64'({1'b0, 6'd28}));

    finish();
  end
endmodule